// File: doc/BRIEF.md
# Sampling Converter Serial Port

This block is the digital face of a successive-approximation sampling converter. A host drives three lines into it: a convert strobe, a serial clock and a serial data input. The block answers on one serial data output with a separate output-enable bit, so a board model or a bench can see when the line floats. The conversion itself is not modelled. The parallel result word presented on `result_in` is captured at the convert rising edge. The word is then held back for a fixed number of system clocks, which stands for the conversion time. After that it is shifted out MSB first as an 18-bit two's-complement value.

The levels of the serial data input and the serial clock at the convert rising edge choose how the frame is delivered. Select mode serves one converter per bus, with the convert line or the data input acting as an active-low select. Chain mode lets several converters share one output line: each stage forwards the word arriving on its data input through the same shift register that holds its own result. Both modes can add a leading completion flag. In select mode the flag is a driven low start bit. In chain mode it is a flag that goes high once the upstream stage reports completion on the data input.

All pins are sampled in the system clock domain. Edges of the convert strobe, the serial clock and the select condition are found by comparing each pin with its value at the previous clock edge.

Top module: `adc_serial_port`

## Requirements
- R1: After reset and before the first conversion, the output is driven low (`sdo_oe`=1, `sdo`=0) exactly when `cnv` and `sdi` are both low, and is high impedance (`sdo_oe`=0) otherwise.
- R2: A rising edge of `cnv` outside a conversion selects select mode when `sdi` is 1 and chain mode when `sdi` is 0, captures `result_in`, and places the output in high impedance. Later changes of `result_in` do not alter the frame.
- R3: A conversion lasts `CONV_CYC` system clocks counted from the `cnv` rising edge. Further `cnv` rising edges during it neither restart it nor change the captured word, and `sdo_oe` stays 0 until it ends.
- R4: In select mode with `cnv` and `sdi` both high at completion, the output stays in high impedance. Once the select condition (`cnv` low or `sdi` low) holds, bit 17 is driven. Each `sck` falling edge presents the next lower bit. The 18th falling edge returns the output to high impedance.
- R5: In select mode with `cnv` or `sdi` low at completion, the output is driven with a start bit of value 0 from completion on. The first `sck` falling edge presents bit 17, and the 19th returns the output to high impedance.
- R6: In select mode, removal of the select condition during a frame returns the output to high impedance. The output stays in high impedance even if the select condition returns before the next conversion.
- R7: In chain mode with `sck` low at the `cnv` rising edge, the output is driven from completion with bit 17. Each `sck` falling edge shifts the register by one place and takes in `sdi`, so an `sdi` level appears on `sdo` after 18 falling edges.
- R8: In chain mode with `sck` high at the `cnv` rising edge, the output is driven 0 from completion until `sdi` is seen high, then driven 1 and held at 1. The first `sck` falling edge consumes this flag and presents bit 17 without shifting.
- R9: `sck` falling edges during a conversion have no effect on the frame that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Convert strobe; rising edge starts a conversion, low level acts as select |
| sck | input | 1 | Serial clock; falling edges advance the frame, level at convert edge requests the chain flag |
| sdi | input | 1 | Serial data input; mode select at convert edge, select line or upstream chain data afterwards |
| result_in | input | DATA_W | Parallel conversion result, captured at the convert rising edge |
| sdo | output | 1 | Serial data output bit |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
Every pin level takes effect at the system clock rising edge that samples it, and the output pair reflects it right after that same edge. The completion response appears exactly `CONV_CYC` rising edges after the edge that saw `cnv` rise. The bench changes its inputs at falling edges and reads `sdo` and `sdo_oe` at the falling edge after the rising edge in question. It also checks the output at `CONV_CYC`-1 edges after the convert edge, so that a conversion ending one clock early or one clock late is caught. Serial clock pulses span two system clocks, and each frame bit is read after the rising edge that saw `sck` fall.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CONV  = 2'd1,
        PH_READY = 2'd2
    } phase_e;

    typedef enum logic {
        IF_CHAIN  = 1'b0,
        IF_SELECT = 1'b1
    } ifmode_e;

    typedef struct packed {
        ifmode_e mode;
        logic    busy;
    } port_cfg_t;

    // positions of the sampled pins inside the sampler vector
    localparam int unsigned P_CNV = 0;
    localparam int unsigned P_SCK = 1;
    localparam int unsigned P_SEL = 2;
    localparam int unsigned P_SDI = 3;
    localparam int unsigned N_PINS = 4;

    function automatic ifmode_e pick_mode(input logic sdi_lvl);
        return sdi_lvl ? IF_SELECT : IF_CHAIN;
    endfunction

endpackage

// File: rtl/sp_pin_sampler.sv
module sp_pin_sampler #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= din[i];
        end
    end
endmodule

// File: rtl/sp_conv_timer.sv
module sp_conv_timer #(
    parameter int unsigned CYC = 142
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic running,
    output logic done
);
    localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= CW'(CYC - 1);
        end
    end

    assign done = running && (cnt == '0);

    // R3: a start request while running neither reloads nor stalls the count
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (running && cnt != '0) |=> (running && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sp_shift_path.sv
module sp_shift_path #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    input  logic         ser_in,
    output logic         head
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= load_val;
        else if (adv)  sh <= {sh[W-2:0], ser_in};
    end

    assign head = sh[W-1];

    // R7: one advance moves the next lower bit to the head
    a_r7_shift_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (head == $past(sh[W-2])));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int unsigned DATA_W   = 18,
    parameter int unsigned CONV_CYC = 142
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] result_in,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int unsigned CNTW = $clog2(DATA_W + 2);
    localparam logic [CNTW-1:0] LAST_PLAIN = CNTW'(DATA_W);
    localparam logic [CNTW-1:0] LAST_FLAG  = CNTW'(DATA_W + 1);

    logic              sel_raw;
    logic [N_PINS-1:0] pin_raw, pin_q;
    logic              conv_go, sck_fall, sel_drop, cs_live, sh_adv;
    logic              tmr_run, tmr_done, head;
    logic [CNTW-1:0]   frame_last, bitcnt;
    phase_e            phase;
    port_cfg_t         cfg;
    logic              flag_pend, flag_hi, spent;
    logic              oe_n, d_n;

    // select condition: convert line low or data input low
    assign sel_raw = ~(cnv & sdi);

    always_comb begin
        pin_raw        = '0;
        pin_raw[P_CNV] = cnv;
        pin_raw[P_SCK] = sck;
        pin_raw[P_SEL] = sel_raw;
        pin_raw[P_SDI] = sdi;
    end

    sp_pin_sampler #(.N(N_PINS)) u_pins (
        .clk (clk),
        .rst (rst),
        .din (pin_raw),
        .q   (pin_q)
    );

    assign conv_go  = cnv & ~pin_q[P_CNV] & (phase != PH_CONV);
    assign sck_fall = ~sck & pin_q[P_SCK];
    assign sel_drop = ~sel_raw & pin_q[P_SEL];
    assign cs_live  = (phase == PH_READY) && (cfg.mode == IF_SELECT)
                      && !spent && pin_q[P_SEL];
    assign sh_adv   = !flag_pend && sck_fall && (phase == PH_READY) &&
                      ((cfg.mode == IF_CHAIN) || (cs_live && !sel_drop));
    assign frame_last = cfg.busy ? LAST_FLAG : LAST_PLAIN;

    sp_conv_timer #(.CYC(CONV_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (conv_go),
        .running (tmr_run),
        .done    (tmr_done)
    );

    sp_shift_path #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (conv_go),
        .load_val (result_in),
        .adv      (sh_adv),
        .ser_in   (sdi),
        .head     (head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg       <= '{mode: IF_CHAIN, busy: 1'b0};
            flag_pend <= 1'b0;
            flag_hi   <= 1'b0;
            spent     <= 1'b0;
            bitcnt    <= '0;
        end else if (conv_go) begin
            phase     <= PH_CONV;
            cfg.mode  <= pick_mode(sdi);
            cfg.busy  <= ~sdi & sck;
            flag_pend <= 1'b0;
            flag_hi   <= 1'b0;
            spent     <= 1'b0;
            bitcnt    <= '0;
        end else if (tmr_done) begin
            phase   <= PH_READY;
            flag_hi <= sdi;
            if (cfg.mode == IF_SELECT) begin
                cfg.busy  <= sel_raw;
                flag_pend <= sel_raw;
            end else begin
                flag_pend <= cfg.busy;
            end
        end else if (phase == PH_READY) begin
            if (cfg.mode == IF_CHAIN) begin
                if (sck_fall)               flag_pend <= 1'b0;
                else if (flag_pend && sdi)  flag_hi   <= 1'b1;
            end else if (!spent) begin
                if (sel_drop) begin
                    spent <= 1'b1;
                end else if (cs_live && sck_fall) begin
                    bitcnt    <= bitcnt + 1'b1;
                    flag_pend <= 1'b0;
                    if (CNTW'(bitcnt + 1'b1) == frame_last) spent <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        oe_n = 1'b0;
        d_n  = 1'b0;
        case (phase)
            PH_IDLE: oe_n = ~pin_q[P_CNV] & ~pin_q[P_SDI];
            PH_READY: begin
                if (cfg.mode == IF_CHAIN) begin
                    oe_n = 1'b1;
                    d_n  = flag_pend ? flag_hi : head;
                end else begin
                    oe_n = pin_q[P_SEL] & ~spent;
                    d_n  = flag_pend ? 1'b0 : head;
                end
            end
            default: ;
        endcase
    end

    assign sdo    = d_n;
    assign sdo_oe = oe_n;

    // R1: both lines low before any conversion drives the output
    a_r1_idle_drive: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !cnv && !sdi) |=> (sdo_oe && !sdo));

    // R2: a convert edge floats the output on the next cycle
    a_r2_start_hiz: assert property (@(posedge clk) disable iff (rst)
        conv_go |=> !sdo_oe);

    // R3: the phase stays in conversion until the timer reports done
    a_r3_conv_holds: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV && !tmr_done) |=> (phase == PH_CONV));

    // R4: the bit count never runs past the frame length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && cfg.mode == IF_SELECT) |-> (bitcnt <= frame_last));

    // R6: a finished or abandoned select frame stays floating
    a_r6_spent_float: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && cfg.mode == IF_SELECT && spent && !conv_go)
        |=> !sdo_oe);

    // R8: once raised, the chain flag stays high until consumed
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && cfg.mode == IF_CHAIN && flag_pend && flag_hi
         && !conv_go) |=> (!flag_pend || flag_hi));
endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
    localparam int unsigned DATA_W   = 18;
    localparam int unsigned CONV_CYC = 142;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnv = 1'b0;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic [DATA_W-1:0] result_in = '0;
    logic sdo, sdo_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_serial_port #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) dut (
        .clk       (clk),
        .rst       (rst),
        .cnv       (cnv),
        .sck       (sck),
        .sdi       (sdi),
        .result_in (result_in),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one serial clock pulse; returns at the falling clk edge after the fall is seen
    task automatic sck_pulse();
        @(negedge clk) sck = 1'b1;
        @(posedge clk);
        @(negedge clk) sck = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    // start a conversion and run it to completion (R2, R3, R9)
    task automatic conv(input logic m_sdi, input logic b_sck, input logic [DATA_W-1:0] data,
                        input logic f_cnv, input logic f_sdi, input bit wig, input string tag);
        @(negedge clk) begin cnv = 1'b0; sck = 1'b0; end
        @(negedge clk) begin result_in = data; sdi = m_sdi; sck = b_sck; cnv = 1'b1; end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 float after convert edge"}, 32'(sdo_oe), 32'd0);
        result_in = ~data;
        cnv = f_cnv;
        sdi = f_sdi;
        sck = 1'b0;
        for (int i = 0; i < int'(CONV_CYC) - 1; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (wig && i >= 4 && i < 12) sck = i[0];
            else                         sck = 1'b0;
            if (i == 20) cnv = 1'b0;
            if (i == 22) cnv = 1'b1;
            if (i == 24) cnv = f_cnv;
        end
        chk({tag, " R3 still converting one clock before end"}, 32'(sdo_oe), 32'd0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cnv = 1'b0;
        sdi = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 float with sdi high after reset", 32'(sdo_oe), 32'd0);
        sdi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 drive when both low", 32'(sdo_oe), 32'd1);
        chk("R1 driven value low", 32'(sdo), 32'd0);
        cnv = 1'b1;
        sdi = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 float once convert rises", 32'(sdo_oe), 32'd0);
        // let this conversion finish in select mode and end its frame
        repeat (CONV_CYC + 2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_cs_plain();
        logic [DATA_W-1:0] d = 18'h2A5C3;
        conv(1'b1, 1'b0, d, 1'b1, 1'b1, 1'b1, "cs_plain");
        chk("R4 float at completion without select", 32'(sdo_oe), 32'd0);
        cnv = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R4 driven after select", 32'(sdo_oe), 32'd1);
        chk("R4 R9 MSB first", 32'(sdo), 32'(d[17]));
        for (int j = 1; j < 18; j++) begin
            sck_pulse();
            chk("R4 frame bit", 32'(sdo), 32'(d[17-j]));
            chk("R4 still driven", 32'(sdo_oe), 32'd1);
        end
        sck_pulse();
        chk("R4 float after 18th fall", 32'(sdo_oe), 32'd0);
    endtask

    task automatic t_cs_flag();
        logic [DATA_W-1:0] d = 18'h20001;
        conv(1'b1, 1'b0, d, 1'b0, 1'b1, 1'b0, "cs_flag");
        chk("R5 driven at completion", 32'(sdo_oe), 32'd1);
        chk("R5 start bit low", 32'(sdo), 32'd0);
        for (int j = 0; j < 18; j++) begin
            sck_pulse();
            chk("R5 frame bit", 32'(sdo), 32'(d[17-j]));
        end
        chk("R5 driven before 19th fall", 32'(sdo_oe), 32'd1);
        sck_pulse();
        chk("R5 float after 19th fall", 32'(sdo_oe), 32'd0);
    endtask

    task automatic t_cs_abort();
        logic [DATA_W-1:0] d = 18'h1B36D;
        conv(1'b1, 1'b0, d, 1'b1, 1'b1, 1'b0, "cs_abort");
        sdi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R6 driven via data line select", 32'(sdo_oe), 32'd1);
        chk("R6 MSB", 32'(sdo), 32'(d[17]));
        for (int j = 1; j < 4; j++) begin
            sck_pulse();
            chk("R6 frame bit", 32'(sdo), 32'(d[17-j]));
        end
        sdi = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 float on deselect", 32'(sdo_oe), 32'd0);
        sdi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R6 stays float on reselect", 32'(sdo_oe), 32'd0);
        sck_pulse();
        chk("R6 stays float after clock", 32'(sdo_oe), 32'd0);
        sdi = 1'b1;
    endtask

    task automatic t_chain_plain();
        logic [DATA_W-1:0] d  = 18'h0F0A5;
        logic [DATA_W-1:0] up = 18'h3C96E;
        conv(1'b0, 1'b0, d, 1'b1, 1'b0, 1'b1, "chain_plain");
        chk("R7 driven at completion", 32'(sdo_oe), 32'd1);
        chk("R7 R9 MSB at completion", 32'(sdo), 32'(d[17]));
        for (int j = 1; j <= 36; j++) begin
            sdi = (j <= 18) ? up[18-j] : 1'b0;
            sck_pulse();
            if (j < 18) chk("R7 own bit", 32'(sdo), 32'(d[17-j]));
            else if (j < 36) chk("R7 upstream bit after 18 falls", 32'(sdo), 32'(up[35-j]));
        end
        sdi = 1'b0;
    endtask

    task automatic t_chain_flag();
        logic [DATA_W-1:0] d = 18'h2C3D1;
        conv(1'b0, 1'b1, d, 1'b1, 1'b0, 1'b0, "chain_flag");
        chk("R8 driven at completion", 32'(sdo_oe), 32'd1);
        chk("R8 flag low while upstream busy", 32'(sdo), 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 flag still low", 32'(sdo), 32'd0);
        sdi = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 flag high after upstream done", 32'(sdo), 32'd1);
        sdi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 flag held high", 32'(sdo), 32'd1);
        for (int j = 0; j < 4; j++) begin
            sck_pulse();
            chk("R8 frame bit after flag", 32'(sdo), 32'(d[17-j]));
        end
    endtask

    initial begin
        t_reset();
        t_cs_plain();
        t_cs_flag();
        t_cs_abort();
        t_chain_plain();
        t_chain_flag();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule